// File: doc/BRIEF.md
# Qualified Bus Ready Synchronizer

This block merges several bus "transfer complete" requests into one ready indication for a processor. Every request line is paired with an active-low enable; a request counts only while its enable is low, and the qualified requests are ORed. The merged request is then brought into the processor clock domain through a synchroniser whose depth is picked by a strap input. One stage samples on the falling clock edge. Two stages sample on the rising edge first and then on the following falling edge.

The output is produced only by a falling-edge register. It is therefore steady across every rising edge at which the processor samples it, and it is held for a full clock period. In a single-bus system all enables are tied low, so each request passes straight through its qualifier. The number of request/enable pairs is a parameter and defaults to two.

Top module: `qualified_ready_sync`

## Requirements
- R1: Request bit i (`bus_req[i]`) contributes only while its enable bit i (`bus_en_n[i]`) is 0. With `bus_en_n[i]` at 1, that request has no effect on `ready`.
- R2: The combined request is 1 when any bit position i has `bus_req[i]`=1 together with `bus_en_n[i]`=0.
- R3: When `one_stage`=1 at a falling edge, `ready` after that edge equals the combined request present at that same falling edge.
- R4: When `one_stage`=0 at a falling edge, `ready` after that edge equals the combined request sampled at the rising edge half a cycle earlier.
- R5: `ready` changes only at falling clock edges. It never changes while the clock is high, so it is stable through each rising edge.
- R6: When `rst`=1 at a clock edge, the synchroniser stages clear. `ready` is 0 from the first falling edge with `rst`=1 onward, for as long as `rst` stays 1.
- R7: A change of `one_stage` takes effect at the next falling edge. Between edges, `ready` shows no intermediate pulse.
- R8: With every enable held at 0 (single-bus use), an asserted request on any line drives `ready` to 1 through the selected path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | NUM_BUS | Ready requests, active high, one bit per bus |
| bus_en_n | input | NUM_BUS | Active-low qualifiers, bit i qualifies bus_req[i] |
| one_stage | input | 1 | 1: single falling-edge stage; 0: rising-then-falling stages |
| ready | output | 1 | Synchronised qualified ready, active high |

## Verification
A wrong value in the rising-edge stage shows at `ready` at the next falling edge, but only in two-stage mode. A stuck or mis-selected output register shows at the very next falling edge in either mode. The bench therefore checks `ready` one time unit after every falling edge, in both modes and across mode switches. It also checks `ready` again after each rising edge, so that a change on the wrong edge is caught within half a cycle. Enable masking is tested with requests raised on disabled lines, and the bench confirms that `ready` stays low.

// File: rtl/ready_sync_pkg.sv
package ready_sync_pkg;

    // Next-state bundle for the synchroniser core.
    typedef struct packed {
        logic rise_stage;   // value captured at rising edge
        logic rdy;          // value captured at falling edge
    } sync_next_t;

endpackage

// File: rtl/ready_qualifier.sv
module ready_qualifier #(
    parameter int NUM_BUS = 2
) (
    input  logic [NUM_BUS-1:0] req,
    input  logic [NUM_BUS-1:0] en_n,
    output logic               any_req
);
    logic [NUM_BUS-1:0] gated;

    // Each request is gated by its own active-low enable.
    for (genvar gi = 0; gi < NUM_BUS; gi++) begin : g_gate
        assign gated[gi] = req[gi] & ~en_n[gi];
    end

    assign any_req = |gated;
endmodule

// File: rtl/ready_sync_core.sv
module ready_sync_core
    import ready_sync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    input  logic one_stage,
    output logic rdy_out
);
    sync_next_t nxt_d;
    logic       rise_q;
    logic       rdy_q;

    // Next-value computation for both stages.
    always_comb begin
        nxt_d            = '0;
        nxt_d.rise_stage = rst ? 1'b0 : req_in;
        if (rst)
            nxt_d.rdy = 1'b0;
        else if (one_stage)
            nxt_d.rdy = req_in;
        else
            nxt_d.rdy = rise_q;
    end

    // First stage of the two-stage path: rising edge.
    always_ff @(posedge clk) begin
        rise_q <= nxt_d.rise_stage;
    end

    // Output stage: falling edge only, so the output holds through rising edges.
    always_ff @(negedge clk) begin
        rdy_q <= nxt_d.rdy;
    end

    assign rdy_out = rdy_q;
endmodule

// File: rtl/qualified_ready_sync.sv
module qualified_ready_sync #(
    parameter int NUM_BUS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BUS-1:0] bus_req,
    input  logic [NUM_BUS-1:0] bus_en_n,
    input  logic               one_stage,
    output logic               ready
);
    logic merged_req;

    ready_qualifier #(.NUM_BUS(NUM_BUS)) u_qual (
        .req     (bus_req),
        .en_n    (bus_en_n),
        .any_req (merged_req)
    );

    ready_sync_core u_core (
        .clk       (clk),
        .rst       (rst),
        .req_in    (merged_req),
        .one_stage (one_stage),
        .rdy_out   (ready)
    );
endmodule

// File: rtl/qualified_ready_sync_chk.sv
module qualified_ready_sync_chk #(
    parameter int NUM_BUS = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_BUS-1:0] bus_req,
    input logic [NUM_BUS-1:0] bus_en_n,
    input logic               one_stage,
    input logic               ready
);
    logic port_req;
    logic rise_seen_q;

    assign port_req = |(bus_req & ~bus_en_n);

    always_ff @(posedge clk) begin
        rise_seen_q <= rst ? 1'b0 : port_req;
    end

    // R3 and R7: single-stage path follows the falling-edge request.
    a_r3_one_stage_path: assert property (@(negedge clk) disable iff (rst)
        one_stage |=> (ready == $past(port_req)));

    // R4 and R7: two-stage path follows the rising-edge sample.
    a_r4_two_stage_path: assert property (@(negedge clk) disable iff (rst)
        !one_stage |=> (ready == $past(rise_seen_q)));

    // R6: reset forces the output low.
    a_r6_reset_clears: assert property (@(negedge clk)
        rst |=> !ready);

    // R1: nothing enabled means no ready in single-stage mode.
    a_r1_masked_idle: assert property (@(negedge clk) disable iff (rst)
        (one_stage && (port_req == 1'b0)) |=> !ready);

    // R5: the output moves only while the clock is low.
    always @(ready) begin
        a_r5_falling_only: assert (clk == 1'b0);
    end
endmodule

bind qualified_ready_sync qualified_ready_sync_chk #(.NUM_BUS(NUM_BUS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_en_n  (bus_en_n),
    .one_stage (one_stage),
    .ready     (ready)
);

// File: tb/qualified_ready_sync_tb.sv
module qualified_ready_sync_tb;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] bus_req = '0;
    logic [NB-1:0] bus_en_n = '1;
    logic          one_stage = 1'b1;
    logic          ready;

    int n_checks = 0;
    int n_fail   = 0;
    logic m_rise = 1'b0;
    logic m_rdy  = 1'b0;

    qualified_ready_sync #(.NUM_BUS(NB)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_en_n  (bus_en_n),
        .one_stage (one_stage),
        .ready     (ready)
    );

    always #5 clk = ~clk;

    function automatic logic qual_f(logic [NB-1:0] r, logic [NB-1:0] e);
        logic acc = 1'b0;
        for (int i = 0; i < NB; i++) acc = acc | (r[i] & ~e[i]);
        return acc;
    endfunction

    // Bench reference built from the requirements.
    always @(posedge clk) m_rise <= rst ? 1'b0 : qual_f(bus_req, bus_en_n);
    always @(negedge clk) m_rdy  <= rst ? 1'b0 : (one_stage ? qual_f(bus_req, bus_en_n) : m_rise);

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ready=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive inputs after a rising edge, check after the falling edge and after the next rising edge.
    task automatic step(input logic r, input logic [NB-1:0] rq, input logic [NB-1:0] en,
                        input logic m, input string tag);
        logic held;
        @(posedge clk); #2;
        rst = r; bus_req = rq; bus_en_n = en; one_stage = m;
        @(negedge clk); #1;
        check(ready, m_rdy, tag);
        held = ready;
        @(posedge clk); #1;
        check(ready, held, "R5 stable over rising edge");
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: ready=%b expected=finish", ready);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R6: reset state
        step(1'b1, 2'b11, 2'b00, 1'b1, "R6 reset with requests");
        check(ready, 1'b0, "R6 ready low in reset");
        step(1'b1, 2'b11, 2'b00, 1'b0, "R6 reset two-stage");
        // R1: requests on disabled lines do nothing
        step(1'b0, 2'b11, 2'b11, 1'b1, "R1 both masked");
        check(ready, 1'b0, "R1 masked gives low");
        step(1'b0, 2'b01, 2'b01, 1'b1, "R1 line0 masked");
        check(ready, 1'b0, "R1 line0 masked low");
        // R2: either qualified line
        step(1'b0, 2'b10, 2'b01, 1'b1, "R2 line1 qualified");
        check(ready, 1'b1, "R2 line1 gives high");
        step(1'b0, 2'b01, 2'b10, 1'b1, "R2 line0 qualified");
        check(ready, 1'b1, "R2 line0 gives high");
        // R8: single-bus use
        step(1'b0, 2'b00, 2'b00, 1'b1, "R8 idle");
        step(1'b0, 2'b10, 2'b00, 1'b1, "R8 request passes");
        check(ready, 1'b1, "R8 high");
        // R4: two-stage delay
        step(1'b0, 2'b00, 2'b00, 1'b0, "R4 drop enters");
        step(1'b0, 2'b00, 2'b00, 1'b0, "R4 drop emerges");
        check(ready, 1'b0, "R4 low after two stages");
        // R7: mode switches
        step(1'b0, 2'b01, 2'b00, 1'b1, "R7 switch to one stage");
        check(ready, 1'b1, "R7 one stage immediate");
        step(1'b0, 2'b00, 2'b00, 1'b0, "R7 switch to two stage");
        check(ready, 1'b1, "R7 two stage shows old sample");
        // R6: reset mid-run
        step(1'b1, 2'b11, 2'b00, 1'b1, "R6 reset mid-run");
        check(ready, 1'b0, "R6 cleared");
        // Random mix
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < 400; k++) begin
            logic rr = ($urandom % 23) == 0;
            logic mm = $urandom % 2;
            step(rr, NB'($urandom), NB'($urandom), mm,
                 rr ? "R6 random reset" : (mm ? "R3 random one stage" : "R4 random two stage"));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule